// File: doc/BRIEF.md
# USB PD Port Sideband Sequencer

This block turns a handful of slow digital status levels around a USB Power Delivery port into the sideband control outputs the board needs: the enable of the port's DC-DC supply, a power-good flag for sink operation, an enable for a battery-charging handshake emulator, a keepalive that tells an upstream hub to stay connected, and a periodic probe that briefly turns on a dead-battery supply while no VBUS is seen. The contract state, the port role and the VBUS measurements arrive from elsewhere (a policy engine, comparators) as plain levels. This block does not decode or produce protocol traffic.

Every input passes through a two-flop synchroniser, and every output is registered. A level change at an input therefore reaches the outputs three clock edges later. The hub-enable path has one more register and takes four edges. The dead-battery probe runs from a prescaler that turns the clock into a slow tick. The probe period and the probe width are counted in those ticks.

When the `COLD_SOCKET` parameter is set, the port enable depends on a plug-insertion input. A falling hub enable is acted on only when a plug is reported, either by the insertion input or by the PD-detect input.

Top module: `pd_port_sideband`

## Requirements
- R1: While reset is held (synchronous, active low), all five outputs are low at every clock edge.
- R2: `pwr_good_o` is high only when there is a contract (`contract_i`=1), the port is a sink (`sink_i`=1), the contract is not the default 5 V / 0 A one (`default_i`=0), and VBUS is in range. Losing any one of these drops it.
- R3: `pwr_good_o` is low whenever `vbus_range_i`=0, even if a sink contract is still held.
- R4: `chg_emu_o` is high when `contract_i`=0 and `vbus_valid_i`=1. Any contract, including a 5 V one, drives it low. It is never high together with `pwr_good_o`.
- R5: With `COLD_SOCKET`=1, `port_en_o` stays low while `insert_n_i`=1. It can rise only after `insert_n_i`=0.
- R6: When `hub_en_i` falls while the port is not a sink under a contract, `port_en_o` goes low and stays low until `hub_en_i` is high again. A fall while the port is a sink with a contract leaves `port_en_o` high.
- R7: A fall of `hub_en_i` is ignored when no plug is reported (`insert_n_i`=1 and `pd_det_n_i`=1). A later insertion with `hub_en_i` still low gives `port_en_o`=1.
- R8: `pd_det_n_i`=0 counts as a reported plug for R6 and R7. A hub fall seen that way keeps `port_en_o` low after a later insertion, until `hub_en_i` returns high.
- R9: While `vbus_present_i`=0, `db_probe_o` pulses. Each pulse is high for `PULSE_TICKS*TICK_DIV` cycles, and pulses repeat every `PERIOD_TICKS*TICK_DIV` cycles.
- R10: While `vbus_present_i`=1, `db_probe_o` stays low.
- R11: `keepalive_o` is high when `vbus_valid_i`=1 or `xfer_busy_i`=1. It is low only when both are 0.
- R12: A change on a status input reaches the outputs after exactly three clock edges: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| contract_i | input | 1 | A power contract is in place |
| sink_i | input | 1 | Port role: 1 = sink, 0 = source |
| default_i | input | 1 | The contract is the default 5 V / 0 A one |
| vbus_range_i | input | 1 | Measured VBUS is inside the window expected for the contract |
| insert_n_i | input | 1 | Plug insertion, active low |
| pd_det_n_i | input | 1 | PD plug detect, active low |
| hub_en_i | input | 1 | Port power request from the hub or host |
| vbus_present_i | input | 1 | Some VBUS voltage is detected |
| vbus_valid_i | input | 1 | VBUS lies in the valid band (about 4.5 V to 22 V) |
| xfer_busy_i | input | 1 | A voltage transition or role swap is in progress |
| port_en_o | output | 1 | Enable for the port's DC-DC supply |
| pwr_good_o | output | 1 | Sink power good |
| chg_emu_o | output | 1 | Charger handshake emulation enable |
| keepalive_o | output | 1 | Tells the hub to keep the port connected |
| db_probe_o | output | 1 | Periodic dead-battery supply enable |

## Verification
Some properties are checked on every cycle:
- all outputs stay low during reset;
- power-good and charger emulation are never high together;
- power-good drops when VBUS is out of range;
- the port stays off while no plug is inserted in cold-socket mode, or after a hub-off event;
- the keepalive holds during transfers;
- the probe stays quiet while VBUS is present, and a single probe pulse never runs longer than its width.

Other behaviours need an ordered sequence and can only be shown by the bench's scenarios:
- the hub-enable edge memory, including which plug inputs arm it;
- the exact three-edge latency;
- the probe period measured between two pulses.

// File: rtl/pdsb_pkg.sv
// Package: shared status record for the PD port sideband sequencer.
// Assumes: every field is a slow level signal that may be asynchronous.
package pdsb_pkg;

    typedef struct packed {
        logic contract;   // contract in place
        logic sink;       // 1 = sink role
        logic dflt;       // default 5 V / 0 A contract
        logic range;      // VBUS within contract window
        logic insert_n;   // plug insertion, active low
        logic pd_det_n;   // PD plug detect, active low
        logic hub_en;     // hub power request
        logic present;    // any VBUS present
        logic valid;      // VBUS in valid band
        logic xfer;       // transition or swap in progress
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    // Idle value: active-low inputs read as deasserted
    localparam status_t STATUS_IDLE = '{insert_n: 1'b1, pd_det_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/pdsb_sync.sv
// Module: pdsb_sync
// Two-flop synchroniser for a vector of independent level inputs.
// Assumes: each bit is a slow level; no bus coherency across bits is needed.
module pdsb_sync #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Capture then re-register each input bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/pdsb_probe.sv
// Module: pdsb_probe
// Slow timebase and periodic dead-battery probe pulse generator.
// A prescaler makes one tick per TICK_DIV clocks; a tick counter spans
// PERIOD_TICKS; the probe is high for the last PULSE_TICKS ticks of each period.
// Assumes: absent_i is already synchronous; counters restart when VBUS returns.
module pdsb_probe #(
    parameter int TICK_DIV     = 125000,
    parameter int PERIOD_TICKS = 10000,
    parameter int PULSE_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic absent_i,
    output logic probe_o
);
    localparam int DIV_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int PER_W     = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam int PULSE_CYC = PULSE_TICKS * TICK_DIV;
    localparam logic [DIV_W-1:0] DIV_LAST    = DIV_W'(TICK_DIV - 1);
    localparam logic [PER_W-1:0] PER_LAST    = PER_W'(PERIOD_TICKS - 1);
    localparam logic [PER_W-1:0] PULSE_START = PER_W'(PERIOD_TICKS - PULSE_TICKS);

    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic             tick;
    logic             probe_q;

    assign tick = (div_q == DIV_LAST);

    // Prescaler: free-runs only while VBUS is absent
    always_ff @(posedge clk) begin
        if (!rst_n || !absent_i) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Period counter: advances once per tick, wraps at the period end
    always_ff @(posedge clk) begin
        if (!rst_n || !absent_i) begin
            per_q <= '0;
        end else if (tick) begin
            per_q <= (per_q == PER_LAST) ? '0 : per_q + 1'b1;
        end
    end

    // Probe output: high in the closing window of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_q <= 1'b0;
        end else begin
            probe_q <= absent_i && (per_q >= PULSE_START);
        end
    end

    assign probe_o = probe_q;

    // Checker state: length of the current high run
    int unsigned hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= 0;
        end else begin
            hi_run_q <= probe_q ? hi_run_q + 1 : 0;
        end
    end

    AST_PROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        probe_q |-> (hi_run_q < PULSE_CYC)); // R9
    AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !absent_i |=> !probe_q); // R10
endmodule

// File: rtl/pdsb_port_ctrl.sv
// Module: pdsb_port_ctrl
// Registered port-level outputs built from the synchronised status record:
// port enable with insertion and hub gating, sink power-good, charger
// emulation enable and VBUS keepalive.
// Assumes: st_i is synchronous; the hub-off memory is set only on a hub fall.
module pdsb_port_ctrl
    import pdsb_pkg::*;
#(
    parameter bit COLD_SOCKET = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  status_t st_i,
    output logic    port_en_o,
    output logic    pwr_good_o,
    output logic    chg_emu_o,
    output logic    keepalive_o
);
    logic hub_prev_q;
    logic hub_off_q;
    logic port_en_q;
    logic pwr_good_q;
    logic chg_emu_q;
    logic keep_q;
    logic plug_seen;
    logic sink_held;
    logic hub_fell;
    logic insert_ok;

    assign plug_seen = !st_i.insert_n || !st_i.pd_det_n;
    assign sink_held = st_i.contract && st_i.sink;
    assign hub_fell  = hub_prev_q && !st_i.hub_en;

    // Insertion gating is applied only when cold-socket mode is built in
    generate
        if (COLD_SOCKET) begin : g_cold
            assign insert_ok = !st_i.insert_n;
        end else begin : g_warm
            assign insert_ok = 1'b1;
        end
    endgenerate

    // Remember the previous hub request to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hub_prev_q <= 1'b0;
        end else begin
            hub_prev_q <= st_i.hub_en;
        end
    end

    // Hub-off memory: set on a qualified fall, cleared by hub high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hub_off_q <= 1'b0;
        end else if (st_i.hub_en) begin
            hub_off_q <= 1'b0;
        end else if (hub_fell && !sink_held && (plug_seen || !COLD_SOCKET)) begin
            hub_off_q <= 1'b1;
        end
    end

    // Output registers for the port-level controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_q  <= 1'b0;
            pwr_good_q <= 1'b0;
            chg_emu_q  <= 1'b0;
            keep_q     <= 1'b0;
        end else begin
            port_en_q  <= insert_ok && !hub_off_q;
            pwr_good_q <= sink_held && !st_i.dflt && st_i.range;
            chg_emu_q  <= !st_i.contract && st_i.valid;
            keep_q     <= st_i.valid || st_i.xfer;
        end
    end

    assign port_en_o   = port_en_q;
    assign pwr_good_o  = pwr_good_q;
    assign chg_emu_o   = chg_emu_q;
    assign keepalive_o = keep_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(port_en_q || pwr_good_q || chg_emu_q || keep_q)); // R1
    AST_PG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_i.range |=> !pwr_good_q); // R3
    AST_PG_CHG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_good_q && chg_emu_q)); // R4
    AST_COLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (COLD_SOCKET && st_i.insert_n) |=> !port_en_q); // R5
    AST_HUB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hub_off_q |=> !port_en_q); // R6
    AST_KEEP_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        st_i.xfer |=> keep_q); // R11
endmodule

// File: rtl/pd_port_sideband.sv
// Module: pd_port_sideband
// Top of the USB PD port sideband sequencer: synchronises the status
// levels, then drives port-level controls and the dead-battery probe.
// Assumes: all status inputs are asynchronous levels; reset is synchronous.
module pd_port_sideband
    import pdsb_pkg::*;
#(
    parameter bit COLD_SOCKET  = 1'b1,
    parameter int TICK_DIV     = 125000,
    parameter int PERIOD_TICKS = 10000,
    parameter int PULSE_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic contract_i,
    input  logic sink_i,
    input  logic default_i,
    input  logic vbus_range_i,
    input  logic insert_n_i,
    input  logic pd_det_n_i,
    input  logic hub_en_i,
    input  logic vbus_present_i,
    input  logic vbus_valid_i,
    input  logic xfer_busy_i,
    output logic port_en_o,
    output logic pwr_good_o,
    output logic chg_emu_o,
    output logic keepalive_o,
    output logic db_probe_o
);
    status_t raw_st;
    status_t sync_st;
    logic [STATUS_W-1:0] sync_bits;

    // Gather the raw levels into one record
    always_comb begin
        raw_st.contract = contract_i;
        raw_st.sink     = sink_i;
        raw_st.dflt     = default_i;
        raw_st.range    = vbus_range_i;
        raw_st.insert_n = insert_n_i;
        raw_st.pd_det_n = pd_det_n_i;
        raw_st.hub_en   = hub_en_i;
        raw_st.present  = vbus_present_i;
        raw_st.valid    = vbus_valid_i;
        raw_st.xfer     = xfer_busy_i;
    end

    pdsb_sync #(
        .W       (STATUS_W),
        .RST_VAL (STATUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_st),
        .q_o   (sync_bits)
    );

    assign sync_st = status_t'(sync_bits);

    pdsb_port_ctrl #(
        .COLD_SOCKET (COLD_SOCKET)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_i        (sync_st),
        .port_en_o   (port_en_o),
        .pwr_good_o  (pwr_good_o),
        .chg_emu_o   (chg_emu_o),
        .keepalive_o (keepalive_o)
    );

    pdsb_probe #(
        .TICK_DIV     (TICK_DIV),
        .PERIOD_TICKS (PERIOD_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .absent_i (!sync_st.present),
        .probe_o  (db_probe_o)
    );
endmodule

// File: tb/pd_port_sideband_test.sv
module pd_port_sideband_test;
    localparam int DIV = 4;
    localparam int PER = 10;
    localparam int PUL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic contract_i = 0, sink_i = 0, default_i = 0, vbus_range_i = 0;
    logic insert_n_i = 1, pd_det_n_i = 1, hub_en_i = 0;
    logic vbus_present_i = 0, vbus_valid_i = 0, xfer_busy_i = 0;
    logic port_en_o, pwr_good_o, chg_emu_o, keepalive_o, db_probe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [4:0] outs;  // {port_en, pwr_good, chg_emu, keepalive, probe}
        int         req;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    pd_port_sideband #(
        .COLD_SOCKET (1'b1),
        .TICK_DIV    (DIV),
        .PERIOD_TICKS(PER),
        .PULSE_TICKS (PUL)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .contract_i(contract_i), .sink_i(sink_i), .default_i(default_i),
        .vbus_range_i(vbus_range_i), .insert_n_i(insert_n_i),
        .pd_det_n_i(pd_det_n_i), .hub_en_i(hub_en_i),
        .vbus_present_i(vbus_present_i), .vbus_valid_i(vbus_valid_i),
        .xfer_busy_i(xfer_busy_i),
        .port_en_o(port_en_o), .pwr_good_o(pwr_good_o), .chg_emu_o(chg_emu_o),
        .keepalive_o(keepalive_o), .db_probe_o(db_probe_o)
    );

    function automatic logic [4:0] outs_now();
        return {port_en_o, pwr_good_o, chg_emu_o, keepalive_o, db_probe_o};
    endfunction

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: v = {contract,sink,dflt,range,insert_n,pd_det_n,hub,present,valid,xfer}
    task automatic step(input logic [9:0] v, input logic [4:0] exp, input int req);
        @(negedge clk);
        {contract_i, sink_i, default_i, vbus_range_i, insert_n_i, pd_det_n_i,
         hub_en_i, vbus_present_i, vbus_valid_i, xfer_busy_i} = v;
        repeat (6) @(negedge clk);
        sbq.push_back('{outs: exp, req: req});
    endtask

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.req, 32'(outs_now()), 32'(e.outs));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int rise1, rise2, width, t;
        // R1: outputs low during reset even with active inputs
        {contract_i, sink_i, vbus_range_i, vbus_valid_i, xfer_busy_i, vbus_present_i} = 6'b111111;
        insert_n_i = 0;
        hub_en_i = 1;
        repeat (5) @(negedge clk);
        check(1, 32'(outs_now()), 32'd0); // R1
        @(negedge clk);
        rst_n = 1;

        // R5: no insertion holds port off; R4: no contract with valid VBUS
        step(10'b0000_11_1110, 5'b00110, 5);
        step(10'b0000_01_1110, 5'b10110, 5);   // R5 inserted
        step(10'b1101_01_1110, 5'b11010, 2);   // R2 sink contract
        step(10'b1100_01_1110, 5'b10010, 3);   // R3 out of range
        step(10'b1111_01_1110, 5'b10010, 2);   // R2 default contract
        step(10'b1001_01_1110, 5'b10010, 4);   // R4 source contract: no emulation
        step(10'b0101_01_1110, 5'b10110, 4);   // R4 contract dropped
        step(10'b0101_01_1100, 5'b10000, 11);  // R11 no VBUS, no transfer
        step(10'b0101_01_1101, 5'b10010, 11);  // R11 transfer holds keepalive
        step(10'b0101_01_0110, 5'b00110, 6);   // R6 hub fall, not sink-held
        step(10'b0101_01_1110, 5'b10110, 6);   // R6 hub back
        step(10'b1101_01_1110, 5'b11010, 6);
        step(10'b1101_01_0110, 5'b11010, 6);   // R6 sink-held: fall ignored
        step(10'b0101_01_1110, 5'b10110, 6);
        step(10'b0101_11_1110, 5'b00110, 7);   // unplug
        step(10'b0101_11_0110, 5'b00110, 7);   // R7 hub fall with no plug
        step(10'b0101_01_0110, 5'b10110, 7);   // R7 insert with hub low: on
        step(10'b0101_01_1110, 5'b10110, 8);
        step(10'b0101_10_1110, 5'b00110, 8);   // PD detect only
        step(10'b0101_10_0110, 5'b00110, 8);   // R8 fall armed by PD detect
        step(10'b0101_00_0110, 5'b00110, 8);   // R8 insert: still off
        step(10'b0101_00_1110, 5'b10110, 8);   // R8 hub back
        while (sbq.size() > 0) @(negedge clk);

        // R12: three-edge latency from contract to power-good
        @(negedge clk);
        contract_i = 1; sink_i = 1; default_i = 0; vbus_range_i = 1;
        @(negedge clk);
        @(negedge clk);
        check(12, 32'(pwr_good_o), 32'd0); // R12 after two edges
        @(negedge clk);
        check(12, 32'(pwr_good_o), 32'd1); // R12 after three edges

        // R10: probe quiet while VBUS present
        t = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (db_probe_o) t++;
        end
        check(10, 32'(t), 32'd0); // R10

        // R9: probe width and period with VBUS absent
        vbus_present_i = 0;
        rise1 = -1; rise2 = -1; width = 0;
        for (int i = 0; i < 400 && rise2 < 0; i++) begin
            logic prev;
            prev = db_probe_o;
            @(negedge clk);
            if (db_probe_o && !prev) begin
                if (rise1 < 0) rise1 = i; else rise2 = i;
            end
            if (db_probe_o && rise1 >= 0 && rise2 < 0) width++;
        end
        check(9, 32'(width), 32'(PUL * DIV));        // R9 width
        check(9, 32'(rise2 - rise1), 32'(PER * DIV)); // R9 period

        // R10: probe stops once VBUS returns
        vbus_present_i = 1;
        repeat (5) @(negedge clk);
        t = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (db_probe_o) t++;
        end
        check(10, 32'(t), 32'd0); // R10

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule